// File: doc/BRIEF.md
# March Test Pattern Generator

This block is the stimulus side of a memory self-test. After a start request it runs a fixed, word-oriented march sequence over every address of a RAM under test. Each cycle it drives one shared address, one write-data word and one write enable, together with separate enables and output-latch set/reset strobes for the two ports of a RAM configured as dual-port. For every read it issues, it presents the data the RAM should return, with a valid strobe, in the cycle the synchronous read data arrives. Comparing that data is left to the response analysers that sit beside the RAMs.

The march is held as a list of phases. Each phase sweeps the address range upward or downward. At every address it visits its read and write operations in order, one per clock. The whole march runs twice: the first pass drives port A and the second drives port B. Just before the first pass, both ports are enabled together for one cycle so that their output-latch resets are exercised. When the RAM runs at its widest data configuration, striped background phases are appended to the solid phases. A one-cycle done pulse closes the run.

Top module: `march_tpg`

## Requirements
- R1: While reset is held and after it is released, with no start applied, every enable, set/reset, write enable, read-valid and done output is 0.
- R2: A start request is accepted only while the block is idle. Start pulses during a run leave the issued sequence unchanged.
- R3: In the cycle after an accepted start, both port enables and both set/reset strobes are 1, the write enable is 0 and the address is 0. This is the only cycle in which both enables are 1 together.
- R4: The solid phases run in this order: up {w 0000}; down {r 0000, w 1111}; up {r 1111, w 0000, r 0000, r 0000, w 1111}; up {r 1111, w 0000}; up {r 0000, w 1111, r 1111, r 1111, w 0000}. All operations of a phase are issued at one address, one per cycle, before the address moves.
- R5: When the wide input is 1 at start, five striped phases follow the solid ones: up {r 0000, w 0101, w 1010, r 1010}; down {r 1010, w 0101, r 0101}; up {r 0101, w 0011, w 1100, r 1100}; down {r 1100, w 0011, r 0011}; up {r 0011}. The wide input is sampled only at start.
- R6: Upward phases go from address 0 to the top address. Downward phases go from the top address to address 0.
- R7: A four-bit pattern written b3b2b1b0 is spread over the data word so that word bit i equals pattern bit (i mod 4). The write data is 0 in every cycle that has no write.
- R8: During the first pass only port A's enable is 1, and during the second pass only port B's. Address, data and write enable are shared by both ports.
- R9: One cycle after a read is issued, the read-valid output is 1 and the expected-data output holds the spread pattern of that read. In every other cycle the read-valid output is 0.
- R10: In the cycle after the last operation of the second pass, done is 1 for exactly one cycle and all enables are 0. The block is then idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| wide_i | input | 1 | Adds the striped background phases (sampled at start) |
| addr_o | output | AW | Shared RAM address |
| wdata_o | output | DW | Shared write data |
| we_o | output | 1 | Shared write enable |
| en_a_o | output | 1 | Port A enable |
| en_b_o | output | 1 | Port B enable |
| srst_a_o | output | 1 | Port A output-latch set/reset |
| srst_b_o | output | 1 | Port B output-latch set/reset |
| rd_valid_o | output | 1 | Expected data is valid this cycle |
| exp_o | output | DW | Expected read data |
| done_o | output | 1 | One-cycle end-of-test pulse |

## Verification
The hardest situation to reach from the ports is a change of configuration or a stray start while a pass is in progress, in particular around phase and pass boundaries. There the sampled wide setting and the pass counter must hold. Besides clean directed runs in both modes, the stimulus toggles the wide input and fires random start pulses on every cycle of a run, up to the last operation. Every issued operation is then compared against a model of the march built independently in the bench. The bench uses a 6-bit data word so that spreading a pattern over a width that is not a multiple of four is also exercised.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef struct packed {
    logic       wr;
    logic [3:0] motif;
  } mop_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_RUN} st_e;

  localparam int NUM_PH   = 10;
  localparam int SOLID_PH = 5;
  localparam int MAX_EL   = 5;

  function automatic mop_t mk(input logic wr, input logic [3:0] m);
    mop_t o;
    o.wr    = wr;
    o.motif = m;
    return o;
  endfunction

  function automatic logic [2:0] ph_len(input logic [3:0] p);
    case (p)
      4'd0:    return 3'd1;
      4'd1:    return 3'd2;
      4'd2:    return 3'd5;
      4'd3:    return 3'd2;
      4'd4:    return 3'd5;
      4'd5:    return 3'd4;
      4'd6:    return 3'd3;
      4'd7:    return 3'd4;
      4'd8:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic ph_down(input logic [3:0] p);
    return (p == 4'd1) || (p == 4'd6) || (p == 4'd8);
  endfunction

  function automatic mop_t ph_op(input logic [3:0] p, input logic [2:0] e);
    mop_t o;
    o = mk(1'b0, 4'h0);
    case (p)
      4'd0: o = mk(1'b1, 4'h0);
      4'd1: o = (e == 3'd0) ? mk(1'b0, 4'h0) : mk(1'b1, 4'hF);
      4'd2: case (e)
              3'd0: o = mk(1'b0, 4'hF);
              3'd1: o = mk(1'b1, 4'h0);
              3'd2, 3'd3: o = mk(1'b0, 4'h0);
              default: o = mk(1'b1, 4'hF);
            endcase
      4'd3: o = (e == 3'd0) ? mk(1'b0, 4'hF) : mk(1'b1, 4'h0);
      4'd4: case (e)
              3'd0: o = mk(1'b0, 4'h0);
              3'd1: o = mk(1'b1, 4'hF);
              3'd2, 3'd3: o = mk(1'b0, 4'hF);
              default: o = mk(1'b1, 4'h0);
            endcase
      4'd5: case (e)
              3'd0: o = mk(1'b0, 4'h0);
              3'd1: o = mk(1'b1, 4'h5);
              3'd2: o = mk(1'b1, 4'hA);
              default: o = mk(1'b0, 4'hA);
            endcase
      4'd6: case (e)
              3'd0: o = mk(1'b0, 4'hA);
              3'd1: o = mk(1'b1, 4'h5);
              default: o = mk(1'b0, 4'h5);
            endcase
      4'd7: case (e)
              3'd0: o = mk(1'b0, 4'h5);
              3'd1: o = mk(1'b1, 4'h3);
              3'd2: o = mk(1'b1, 4'hC);
              default: o = mk(1'b0, 4'hC);
            endcase
      4'd8: case (e)
              3'd0: o = mk(1'b0, 4'hC);
              3'd1: o = mk(1'b1, 4'h3);
              default: o = mk(1'b0, 4'h3);
            endcase
      default: o = mk(1'b0, 4'h3);
    endcase
    return o;
  endfunction

endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          load_down_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          down_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      down_q <= load_down_i;
      addr_q <= load_down_i ? TOP : '0;
    end else if (step_i) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr_o   = addr_q;
  assign at_end_o = down_q ? (addr_q == '0) : (addr_q == TOP);

  wire step_up_w = step_i && !load_i && !down_q;
  wire step_dn_w = step_i && !load_i && down_q;

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_w |=> (addr_o == $past(addr_o) + AW'(1)));
  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_w |=> (addr_o == $past(addr_o) - AW'(1)));
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_i,
  input  logic at_end_i,
  output logic init_o,
  output logic run_o,
  output logic iter_o,
  output mop_t op_o,
  output logic load_o,
  output logic load_down_o,
  output logic step_o,
  output logic start_acc_o,
  output logic done_o
);
  st_e        state_q;
  logic [3:0] phase_q;
  logic [2:0] elem_q;
  logic       iter_q;
  logic       wide_q;
  logic       done_q;

  wire last_el_w = (elem_q == ph_len(phase_q) - 3'd1);
  wire [3:0] last_ph_w = wide_q ? 4'(NUM_PH - 1) : 4'(SOLID_PH - 1);
  wire last_ph_hit_w = (phase_q == last_ph_w);

  assign start_acc_o = (state_q == ST_IDLE) && start_i;
  assign init_o      = (state_q == ST_INIT);
  assign run_o       = (state_q == ST_RUN);
  assign iter_o      = iter_q;
  assign op_o        = ph_op(phase_q, elem_q);
  assign done_o      = done_q;

  wire sweep_end_w = run_o && last_el_w && at_end_i;
  wire pass_end_w  = sweep_end_w && last_ph_hit_w;

  always_comb begin
    step_o      = run_o && last_el_w && !at_end_i;
    load_o      = start_acc_o || sweep_end_w;
    load_down_o = 1'b0;
    if (sweep_end_w && !last_ph_hit_w) load_down_o = ph_down(phase_q + 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      elem_q  <= '0;
      iter_q  <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_INIT;
          wide_q  <= wide_i;
          iter_q  <= 1'b0;
          phase_q <= '0;
          elem_q  <= '0;
        end
        ST_INIT: state_q <= ST_RUN;
        default: begin
          if (!last_el_w) begin
            elem_q <= elem_q + 3'd1;
          end else begin
            elem_q <= '0;
            if (at_end_i) begin
              if (!last_ph_hit_w) begin
                phase_q <= phase_q + 4'd1;
              end else if (!iter_q) begin
                iter_q  <= 1'b1;
                phase_q <= '0;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pass_end_w));
endmodule

// File: rtl/march_rd_pipe.sv
module march_rd_pipe #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [DW-1:0] word_i,
  output logic          valid_o,
  output logic [DW-1:0] exp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      exp_o   <= '0;
    end else begin
      valid_o <= issue_i;
      exp_o   <= issue_i ? word_i : '0;
    end
  end
endmodule

// File: rtl/march_tpg.sv
module march_tpg
  import march_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          en_a_o,
  output logic          en_b_o,
  output logic          srst_a_o,
  output logic          srst_b_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] exp_o,
  output logic          done_o
);
  function automatic logic [DW-1:0] spread(input logic [3:0] m);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = m[i % 4];
    return w;
  endfunction

  logic init_w, run_w, iter_w, load_w, load_down_w, step_w, at_end_w, start_acc_w;
  mop_t op_w;

  march_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .at_end_i(at_end_w), .init_o(init_w), .run_o(run_w), .iter_o(iter_w),
    .op_o(op_w), .load_o(load_w), .load_down_o(load_down_w), .step_o(step_w),
    .start_acc_o(start_acc_w), .done_o(done_o)
  );

  march_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .load_down_i(load_down_w),
    .step_i(step_w), .addr_o(addr_o), .at_end_o(at_end_w)
  );

  wire [DW-1:0] word_w   = spread(op_w.motif);
  wire          rd_iss_w = run_w && !op_w.wr;

  march_rd_pipe #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue_i(rd_iss_w), .word_i(word_w),
    .valid_o(rd_valid_o), .exp_o(exp_o)
  );

  assign we_o     = run_w && op_w.wr;
  assign wdata_o  = we_o ? word_w : '0;
  assign en_a_o   = init_w || (run_w && !iter_w);
  assign en_b_o   = init_w || (run_w && iter_w);
  assign srst_a_o = init_w;
  assign srst_b_o = init_w;

  assert_dual_only_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_o && en_b_o) |-> $past(start_acc_w));
  assert_write_single_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (en_a_o != en_b_o));
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> ($past(en_a_o ^ en_b_o) && !$past(we_o)));
  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!en_a_o && !en_b_o && !we_o));
endmodule

// File: tb/test_march_tpg.sv
module test_march_tpg;
  localparam int AW = 3;
  localparam int DW = 6;
  localparam int TOPA = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic wide_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o, exp_o;
  logic we_o, en_a_o, en_b_o, srst_a_o, srst_b_o, rd_valid_o, done_o;

  int n_run = 0;
  int n_fail = 0;
  logic pend_rd = 1'b0;
  logic [DW-1:0] pend_exp = '0;

  always #4 clk = ~clk;

  march_tpg #(.AW(AW), .DW(DW)) i_march_tpg (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .we_o(we_o), .en_a_o(en_a_o),
    .en_b_o(en_b_o), .srst_a_o(srst_a_o), .srst_b_o(srst_b_o),
    .rd_valid_o(rd_valid_o), .exp_o(exp_o), .done_o(done_o)
  );

  // bench model of the march: {is_write, pattern}
  function automatic int b_count(int p);
    int n [10] = '{1, 2, 5, 2, 5, 4, 3, 4, 3, 1};
    return n[p];
  endfunction

  function automatic bit b_desc(int p);
    return (p == 1) || (p == 6) || (p == 8);
  endfunction

  function automatic logic [4:0] b_elem(int p, int e);
    logic [4:0] t [10][5] = '{
      '{5'h10, 5'h00, 5'h00, 5'h00, 5'h00},
      '{5'h00, 5'h1F, 5'h00, 5'h00, 5'h00},
      '{5'h0F, 5'h10, 5'h00, 5'h00, 5'h1F},
      '{5'h0F, 5'h10, 5'h00, 5'h00, 5'h00},
      '{5'h00, 5'h1F, 5'h0F, 5'h0F, 5'h10},
      '{5'h00, 5'h15, 5'h1A, 5'h0A, 5'h00},
      '{5'h0A, 5'h15, 5'h05, 5'h00, 5'h00},
      '{5'h05, 5'h13, 5'h1C, 5'h0C, 5'h00},
      '{5'h0C, 5'h13, 5'h03, 5'h00, 5'h00},
      '{5'h03, 5'h00, 5'h00, 5'h00, 5'h00}};
    return t[p][e];
  endfunction

  function automatic logic [DW-1:0] b_word(logic [3:0] m);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < DW; i++) if (m[i & 3]) w[i] = 1'b1;
    return w;
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic check_rd();
    n_run++;
    if (rd_valid_o !== pend_rd) fail("R9", "rd_valid", rd_valid_o, pend_rd);
    else if (pend_rd && exp_o !== pend_exp) fail("R9", "exp", exp_o, pend_exp);
  endtask

  task automatic run_march(bit wide, bit noise);
    int nph = wide ? 10 : 5;
    @(negedge clk);
    start_i = 1'b1;
    wide_i  = wide;
    @(negedge clk);
    start_i = 1'b0;
    n_run++;
    if ({en_a_o, en_b_o, srst_a_o, srst_b_o, we_o} !== 5'b11110 || addr_o !== '0)
      fail("R3", "init cycle en/srst/we", {en_a_o, en_b_o, srst_a_o, srst_b_o, we_o}, 5'b11110);
    pend_rd = 1'b0;
    check_rd();
    if (noise) begin
      wide_i = ~wide;
      start_i = 1'b1;
    end
    for (int it = 0; it < 2; it++)
      for (int p = 0; p < nph; p++)
        for (int k = 0; k <= TOPA; k++)
          for (int e = 0; e < b_count(p); e++) begin
            int a = b_desc(p) ? TOPA - k : k;
            logic [4:0] el = b_elem(p, e);
            logic [DW-1:0] w = b_word(el[3:0]);
            @(negedge clk);
            check_rd();
            n_run++;
            if (addr_o !== AW'(a)) fail("R6", "addr", addr_o, a);
            else if (we_o !== el[4]) fail("R4 R5", "we", we_o, el[4]);
            else if (wdata_o !== (el[4] ? w : '0)) fail("R7", "wdata", wdata_o, el[4] ? w : '0);
            else if (en_a_o !== (it == 0) || en_b_o !== (it == 1))
              fail("R8", "port enables", {en_a_o, en_b_o}, it == 0 ? 2 : 1);
            else if (done_o !== 1'b0 || srst_a_o || srst_b_o)
              fail("R10", "early done/srst", {done_o, srst_a_o, srst_b_o}, 0);
            pend_rd  = !el[4];
            pend_exp = w;
            if (noise) begin
              start_i = ($urandom % 4) == 0;
              wide_i  = $urandom % 2;
            end
          end
    @(negedge clk);
    start_i = 1'b0;
    check_rd();
    n_run++;
    if (done_o !== 1'b1 || en_a_o || en_b_o || we_o)
      fail("R10", "done pulse", {done_o, en_a_o, en_b_o, we_o}, 8);
    pend_rd = 1'b0;
    @(negedge clk);
    check_rd();
    n_run++;
    if (done_o !== 1'b0 || en_a_o || en_b_o || we_o)
      fail("R10", "idle after done", {done_o, en_a_o, en_b_o, we_o}, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    n_run++;
    if ({en_a_o, en_b_o, srst_a_o, srst_b_o, we_o, rd_valid_o, done_o} !== 7'b0)
      fail("R1", "outputs in reset", {en_a_o, en_b_o, srst_a_o, srst_b_o, we_o, rd_valid_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_run++;
    if ({en_a_o, en_b_o, srst_a_o, srst_b_o, we_o, rd_valid_o, done_o} !== 7'b0)
      fail("R1", "outputs idle", {en_a_o, en_b_o, srst_a_o, srst_b_o, we_o, rd_valid_o, done_o}, 0);
    run_march(1'b0, 1'b0);   // R4 solid only
    run_march(1'b1, 1'b0);   // R5 with backgrounds
    for (int r = 0; r < 4; r++) begin
      repeat ($urandom % 5) @(negedge clk);
      run_march(r[0], 1'b1); // R2 and R5 under stray starts and toggling config
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule